// File: doc/BRIEF.md
# In-Band Software Flow Controller

This block handles character-based (XON/XOFF) flow control for one UART channel. On the receive path it sits between the deserializer and the receive FIFO. Each received character is compared with four programmable control characters. Two of them are "stop" characters and two are "go" characters, arranged as a first pair and a second pair. When a character in the selected set is recognised, the block pauses or releases the local transmitter. That character is then dropped instead of being written into the FIFO. Every recognition also sets a sticky per-character flag, which stays set until software clears it.

On the transmit path the block watches the receive FIFO fill level. The halt and resume thresholds are each a 4-bit count in units of eight entries. When the level reaches the halt threshold, the block asks the serializer to insert the selected stop characters. Once the level has drained to the resume threshold, and only if a stop was sent earlier, it asks for the matching go characters. Each insertion uses a request/acknowledge handshake, one character per acknowledge. The receive-side selection and the transmit-side selection are independent 2-bit fields. A single enable input gates all of this behaviour.

Top module: `swflow_ctl`

## Requirements
- R1: After reset, `tx_paused`, `ins_req`, `fifo_wr_en` and `match_flags` are all 0.
- R2: Receive selection 2'b01 recognises only the second pair, and 2'b10 recognises only the first pair. A recognised stop character sets `tx_paused` on the clock edge that samples it, and a recognised go character clears it. Characters of the other pair have no effect on `tx_paused`.
- R3: Receive selection 2'b11 treats the pairs as sequences. Stop-1 received directly followed by stop-2 pauses the transmitter, and go-1 directly followed by go-2 releases it. Any other character in between breaks the sequence, and stop-2 or go-2 alone has no effect.
- R4: With receive selection 2'b00, or with `sw_flow_en` low, no received character changes `tx_paused` or `match_flags`, and every character is forwarded to the FIFO.
- R5: A character in the active recognised set (both pairs under 2'b11) is not written to the FIFO. Every other character is written one cycle after it is received (`fifo_wr_en` high for one cycle), with identical data.
- R6: `match_flags` bit 0 = go-1, bit 1 = go-2, bit 2 = stop-1, bit 3 = stop-2. A flag is set when its character is recognised in the active set. It holds until a cycle with the matching `flag_clr` bit high, and a new recognition in that same cycle wins over the clear.
- R7: While `sw_flow_en` is low, `tx_paused` and `ins_req` are 0 from the next cycle on, and the memory of a sent stop is forgotten.
- R8: With a nonzero halt field H and no stop sent yet, a level of at least 8*H raises `ins_req` on the next cycle. Transmit selection 2'b01 requests stop-2, 2'b10 requests stop-1, and 2'b11 requests stop-1 then stop-2. A halt field of 0 never requests.
- R9: A go request (same pair order as R8) starts only after a full stop sequence was acknowledged and the level is at most 8*R, where R is the resume field. Between the thresholds nothing is requested, and after the go sequence nothing further is requested until the halt threshold is reached again.
- R10: `ins_req` and `ins_char` hold until `ins_ack`. Each acknowledged cycle consumes exactly one character.
- R11: Transmit selection 2'b00 never raises `ins_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_flow_en | input | 1 | Global enable for software flow control |
| rx_sel | input | 2 | Receive-side pair selection |
| tx_sel | input | 2 | Transmit-side pair selection |
| go1_char | input | 8 | First go character |
| go2_char | input | 8 | Second go character |
| stop1_char | input | 8 | First stop character |
| stop2_char | input | 8 | Second stop character |
| halt_lvl | input | 4 | Halt threshold in units of 8 entries |
| resume_lvl | input | 4 | Resume threshold in units of 8 entries |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_level | input | 8 | Receive FIFO fill level (0..128) |
| flag_clr | input | 4 | Per-flag clear strobes |
| fifo_wr_en | output | 1 | Write strobe towards the receive FIFO |
| fifo_wr_data | output | 8 | Character written to the receive FIFO |
| tx_paused | output | 1 | Transmitter hold request |
| match_flags | output | 4 | Sticky recognition flags |
| ins_req | output | 1 | Request to insert a flow character |
| ins_char | output | 8 | Flow character to insert |
| ins_ack | input | 1 | Serializer accepted `ins_char` |

## Verification
The hardest state to reach is the middle of the transmit hysteresis band after a stop sequence has completed. Getting there needs a level above halt, two acknowledged insertions under the both-pair selection, and then a level that lies strictly between the thresholds. The stimulus walks the level through exactly 16, 9 and 8 with halt 2 and resume 1, so that each boundary is hit at equality. A second hard case is a broken receive sequence: a plain character arrives between go-1 and go-2. The scoreboard then has to see that plain character come out of the FIFO write port while the pause stays in force.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    // Flag and compare-vector positions
    localparam int IDX_GO1   = 0;
    localparam int IDX_GO2   = 1;
    localparam int IDX_STOP1 = 2;
    localparam int IDX_STOP2 = 3;
    localparam int NUM_CTRL  = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'b00,
        SEL_SECOND = 2'b01,
        SEL_FIRST  = 2'b10,
        SEL_BOTH   = 2'b11
    } pair_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_LEAD  = 2'b01,
        PH_TRAIL = 2'b10
    } ins_phase_e;
endpackage

// File: rtl/swfc_char_cmp.sv
module swfc_char_cmp #(
    parameter int CHAR_W = 8,
    parameter int NREF   = 4
) (
    input  logic [CHAR_W-1:0]           ch,
    input  logic [NREF-1:0][CHAR_W-1:0] refs,
    output logic [NREF-1:0]             hit
);
    for (genvar g = 0; g < NREF; g++) begin : g_cmp
        assign hit[g] = (ch == refs[g]);
    end
endmodule

// File: rtl/swfc_rx_ctl.sv
module swfc_rx_ctl
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [1:0]                      sel,
    input  logic [NUM_CTRL-1:0][CHAR_W-1:0] refs,
    input  logic                            rx_valid,
    input  logic [CHAR_W-1:0]               rx_char,
    input  logic [NUM_CTRL-1:0]             flag_clr,
    output logic                            fifo_wr_en,
    output logic [CHAR_W-1:0]               fifo_wr_data,
    output logic                            paused,
    output logic [NUM_CTRL-1:0]             flags
);
    typedef struct packed {
        logic                paused;
        logic                after_stop1;
        logic                after_go1;
        logic                wr_en;
        logic [CHAR_W-1:0]   wr_data;
        logic [NUM_CTRL-1:0] flags;
    } rx_state_t;

    rx_state_t state_d, state_q;
    logic [NUM_CTRL-1:0] hit_all, act_mask, hit_act;

    swfc_char_cmp #(.CHAR_W(CHAR_W), .NREF(NUM_CTRL)) cmp_i (
        .ch   (rx_char),
        .refs (refs),
        .hit  (hit_all)
    );

    always_comb begin
        act_mask = '0;
        if (en) begin
            unique case (pair_sel_e'(sel))
                SEL_SECOND: begin
                    act_mask[IDX_GO2]   = 1'b1;
                    act_mask[IDX_STOP2] = 1'b1;
                end
                SEL_FIRST: begin
                    act_mask[IDX_GO1]   = 1'b1;
                    act_mask[IDX_STOP1] = 1'b1;
                end
                SEL_BOTH: act_mask = '1;
                default:  act_mask = '0;
            endcase
        end
        hit_act = hit_all & act_mask;
    end

    always_comb begin
        state_d       = state_q;
        state_d.wr_en = 1'b0;
        state_d.flags = state_q.flags & ~flag_clr;
        if (!en || pair_sel_e'(sel) != SEL_BOTH) begin
            state_d.after_stop1 = 1'b0;
            state_d.after_go1   = 1'b0;
        end
        if (!en) begin
            state_d.paused = 1'b0;
        end
        if (rx_valid) begin
            state_d.flags = state_d.flags | hit_act;
            if (hit_act == '0) begin
                state_d.wr_en   = 1'b1;
                state_d.wr_data = rx_char;
            end
            if (pair_sel_e'(sel) == SEL_BOTH && en) begin
                if (hit_act[IDX_STOP2] && state_q.after_stop1) begin
                    state_d.paused = 1'b1;
                end else if (hit_act[IDX_GO2] && state_q.after_go1) begin
                    state_d.paused = 1'b0;
                end
                state_d.after_stop1 = hit_act[IDX_STOP1];
                state_d.after_go1   = hit_act[IDX_GO1];
            end else if (hit_act[IDX_STOP1] || hit_act[IDX_STOP2]) begin
                state_d.paused = 1'b1;
            end else if (hit_act[IDX_GO1] || hit_act[IDX_GO2]) begin
                state_d.paused = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fifo_wr_en   = state_q.wr_en;
    assign fifo_wr_data = state_q.wr_data;
    assign paused       = state_q.paused;
    assign flags        = state_q.flags;

    assert_pause_drops_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !paused);

    assert_pause_needs_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(rx_valid) && $past(en));

    assert_write_carries_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> $past(rx_valid) && ($past(rx_char) == fifo_wr_data));

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags & ~$past(flag_clr)) == '0));
endmodule

// File: rtl/swfc_tx_gen.sv
module swfc_tx_gen
    import swfc_pkg::*;
#(
    parameter int CHAR_W   = 8,
    parameter int LVL_W    = 8,
    parameter int THR_W    = 4,
    parameter int UNIT_SH  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [1:0]                      sel,
    input  logic [NUM_CTRL-1:0][CHAR_W-1:0] refs,
    input  logic [THR_W-1:0]                halt_lvl,
    input  logic [THR_W-1:0]                resume_lvl,
    input  logic [LVL_W-1:0]                level,
    input  logic                            ins_ack,
    output logic                            ins_req,
    output logic [CHAR_W-1:0]               ins_char
);
    localparam int CMP_W = ((LVL_W > THR_W + UNIT_SH) ? LVL_W : THR_W + UNIT_SH) + 1;

    typedef struct packed {
        ins_phase_e phase;
        logic       two_step;
        logic       use_second;
        logic       is_stop;
        logic       stop_sent;
    } tx_state_t;

    tx_state_t state_d, state_q;
    logic [CMP_W-1:0] lvl_ext, halt_thr, resume_thr;
    logic             over_halt, under_resume;

    always_comb begin
        lvl_ext      = CMP_W'(level);
        halt_thr     = CMP_W'(halt_lvl) << UNIT_SH;
        resume_thr   = CMP_W'(resume_lvl) << UNIT_SH;
        over_halt    = (halt_lvl != '0) && (lvl_ext >= halt_thr);
        under_resume = (lvl_ext <= resume_thr);
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = '0;
        end else begin
            unique case (state_q.phase)
                PH_IDLE: begin
                    if (pair_sel_e'(sel) != SEL_NONE) begin
                        if ((!state_q.stop_sent && over_halt) ||
                            (state_q.stop_sent && under_resume)) begin
                            state_d.phase      = PH_LEAD;
                            state_d.two_step   = (pair_sel_e'(sel) == SEL_BOTH);
                            state_d.use_second = (pair_sel_e'(sel) == SEL_SECOND);
                            state_d.is_stop    = !state_q.stop_sent;
                        end
                    end
                end
                PH_LEAD: begin
                    if (ins_ack) begin
                        if (state_q.two_step) begin
                            state_d.phase = PH_TRAIL;
                        end else begin
                            state_d.phase     = PH_IDLE;
                            state_d.stop_sent = state_q.is_stop;
                        end
                    end
                end
                PH_TRAIL: begin
                    if (ins_ack) begin
                        state_d.phase     = PH_IDLE;
                        state_d.stop_sent = state_q.is_stop;
                    end
                end
                default: state_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        logic second;
        second  = (state_q.phase == PH_TRAIL) || state_q.use_second;
        ins_req = (state_q.phase != PH_IDLE);
        if (state_q.is_stop) begin
            ins_char = second ? refs[IDX_STOP2] : refs[IDX_STOP1];
        end else begin
            ins_char = second ? refs[IDX_GO2] : refs[IDX_GO1];
        end
    end

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && !ins_ack && en |=> ins_req);

    assert_req_drops_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ins_req);

    assert_no_req_without_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> ($past(sel) != 2'b00) && $past(en));
endmodule

// File: rtl/swflow_ctl.sv
module swflow_ctl
    import swfc_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int THR_W      = 4,
    parameter int LVL_UNIT   = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_flow_en,
    input  logic [1:0]        rx_sel,
    input  logic [1:0]        tx_sel,
    input  logic [CHAR_W-1:0] go1_char,
    input  logic [CHAR_W-1:0] go2_char,
    input  logic [CHAR_W-1:0] stop1_char,
    input  logic [CHAR_W-1:0] stop2_char,
    input  logic [THR_W-1:0]  halt_lvl,
    input  logic [THR_W-1:0]  resume_lvl,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [3:0]        flag_clr,
    output logic              fifo_wr_en,
    output logic [CHAR_W-1:0] fifo_wr_data,
    output logic              tx_paused,
    output logic [3:0]        match_flags,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char,
    input  logic              ins_ack
);
    localparam int UNIT_SH = $clog2(LVL_UNIT);

    logic [NUM_CTRL-1:0][CHAR_W-1:0] refs;

    always_comb begin
        refs[IDX_GO1]   = go1_char;
        refs[IDX_GO2]   = go2_char;
        refs[IDX_STOP1] = stop1_char;
        refs[IDX_STOP2] = stop2_char;
    end

    swfc_rx_ctl #(.CHAR_W(CHAR_W)) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (sw_flow_en),
        .sel          (rx_sel),
        .refs         (refs),
        .rx_valid     (rx_valid),
        .rx_char      (rx_char),
        .flag_clr     (flag_clr),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .paused       (tx_paused),
        .flags        (match_flags)
    );

    swfc_tx_gen #(
        .CHAR_W  (CHAR_W),
        .LVL_W   (LVL_W),
        .THR_W   (THR_W),
        .UNIT_SH (UNIT_SH)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sw_flow_en),
        .sel        (tx_sel),
        .refs       (refs),
        .halt_lvl   (halt_lvl),
        .resume_lvl (resume_lvl),
        .level      (rx_level),
        .ins_ack    (ins_ack),
        .ins_req    (ins_req),
        .ins_char   (ins_char)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !ins_req && !tx_paused);
endmodule

// File: tb/swflow_ctl_tb.sv
module swflow_ctl_tb_top;
    localparam logic [7:0] GO1 = 8'h11, GO2 = 8'h12, ST1 = 8'h13, ST2 = 8'h14;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sw_flow_en = 1'b0;
    logic [1:0] rx_sel = 2'b00, tx_sel = 2'b00;
    logic [3:0] halt_lvl = 4'd0, resume_lvl = 4'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic [7:0] rx_level = 8'd0;
    logic [3:0] flag_clr = 4'b0;
    logic       ins_ack = 1'b0;
    logic       fifo_wr_en, tx_paused, ins_req;
    logic [7:0] fifo_wr_data, ins_char;
    logic [3:0] match_flags;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    swflow_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sw_flow_en(sw_flow_en),
        .rx_sel(rx_sel), .tx_sel(tx_sel),
        .go1_char(GO1), .go2_char(GO2), .stop1_char(ST1), .stop2_char(ST2),
        .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_level(rx_level),
        .flag_clr(flag_clr), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .tx_paused(tx_paused), .match_flags(match_flags),
        .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    // Driver: one character; pushes it to the scoreboard if it should reach the FIFO
    task automatic send(input logic [7:0] c, input bit passes);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_char  = c;
        if (passes) exp_q.push_back(c);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        ins_ack = 1'b1;
        @(negedge clk);
        ins_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares every FIFO write with the scoreboard head (R5)
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected write", {24'd0, fifo_wr_data}, 32'hFFFF);
            end else begin
                chk("R5 write data", {24'd0, fifo_wr_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 paused", tx_paused, 0);
        chk("R1 ins_req", ins_req, 0);
        chk("R1 flags", match_flags, 0);
        chk("R1 wr_en", fifo_wr_en, 0);
        rst_n = 1'b1;
        sw_flow_en = 1'b1;
        rx_sel = 2'b01;
        idle(1);

        // R2: second pair
        send(8'h41, 1);  chk("R2 plain", tx_paused, 0);
        send(ST1, 1);    chk("R2 other pair stop", tx_paused, 0);
        send(ST2, 0);    chk("R2 stop2 pauses", tx_paused, 1);
        send(GO1, 1);    chk("R2 other pair go", tx_paused, 1);
        send(GO2, 0);    chk("R2 go2 resumes", tx_paused, 0);
        chk("R6 flags second pair", match_flags, 4'b1010);
        idle(3);
        chk("R6 flags held", match_flags, 4'b1010);
        @(negedge clk); flag_clr = 4'b0010;
        @(negedge clk); flag_clr = 4'b0000;
        chk("R6 partial clear", match_flags, 4'b1000);
        @(negedge clk); flag_clr = 4'b1111;
        @(negedge clk); flag_clr = 4'b0000;
        chk("R6 cleared", match_flags, 4'b0000);

        // R2: first pair
        rx_sel = 2'b10;
        send(ST1, 0);    chk("R2 stop1 pauses", tx_paused, 1);
        send(ST2, 1);    chk("R2 stop2 ignored", tx_paused, 1);
        send(GO2, 1);    chk("R2 go2 ignored", tx_paused, 1);
        send(GO1, 0);    chk("R2 go1 resumes", tx_paused, 0);
        chk("R6 flags first pair", match_flags, 4'b0101);
        // R6: set wins over clear
        @(negedge clk); rx_valid = 1'b1; rx_char = GO1; flag_clr = 4'b1111;
        @(negedge clk); rx_valid = 1'b0; flag_clr = 4'b0000;
        chk("R6 set beats clear", match_flags, 4'b0001);
        @(negedge clk); flag_clr = 4'b1111;
        @(negedge clk); flag_clr = 4'b0000;

        // R3: sequences
        rx_sel = 2'b11;
        send(ST2, 0);    chk("R3 lone stop2", tx_paused, 0);
        send(ST1, 0);    chk("R3 stop1 alone", tx_paused, 0);
        send(ST2, 0);    chk("R3 stop sequence", tx_paused, 1);
        send(GO1, 0);
        send(8'h42, 1);
        send(GO2, 0);    chk("R3 broken go sequence", tx_paused, 1);
        send(GO1, 0);
        send(GO2, 0);    chk("R3 go sequence", tx_paused, 0);
        @(negedge clk); flag_clr = 4'b1111;
        @(negedge clk); flag_clr = 4'b0000;

        // R4: selection none, then disabled
        rx_sel = 2'b00;
        send(ST2, 1);    chk("R4 none no pause", tx_paused, 0);
        chk("R4 none no flags", match_flags, 0);
        rx_sel = 2'b10;
        send(ST1, 0);    chk("R7 paused before disable", tx_paused, 1);
        @(negedge clk); sw_flow_en = 1'b0;
        @(negedge clk);
        chk("R7 disable clears pause", tx_paused, 0);
        @(negedge clk); flag_clr = 4'b1111;
        @(negedge clk); flag_clr = 4'b0000;
        send(ST1, 1);    chk("R4 disabled no pause", tx_paused, 0);
        chk("R4 disabled no flags", match_flags, 0);
        idle(2);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        // Transmit side
        sw_flow_en = 1'b1;
        rx_sel = 2'b00;
        tx_sel = 2'b11;
        halt_lvl = 4'd2;
        resume_lvl = 4'd1;
        rx_level = 8'd15;
        idle(2);
        chk("R8 below halt", ins_req, 0);
        rx_level = 8'd16;
        @(negedge clk);
        chk("R8 req at halt", ins_req, 1);
        chk("R8 first stop1", ins_char, ST1);
        @(negedge clk);
        chk("R10 req held", ins_req, 1);
        chk("R10 char held", ins_char, ST1);
        ack();
        chk("R8 then stop2", ins_char, ST2);
        chk("R10 still requesting", ins_req, 1);
        ack();
        chk("R10 done after two acks", ins_req, 0);
        idle(2);
        chk("R9 no repeat at halt", ins_req, 0);
        rx_level = 8'd9;
        idle(3);
        chk("R9 hysteresis band", ins_req, 0);
        rx_level = 8'd8;
        @(negedge clk);
        chk("R9 go1 at resume", ins_char, GO1);
        chk("R9 req at resume", ins_req, 1);
        ack();
        chk("R9 then go2", ins_char, GO2);
        ack();
        rx_level = 8'd0;
        idle(3);
        chk("R9 no go without stop", ins_req, 0);

        tx_sel = 2'b01;
        rx_level = 8'd20;
        @(negedge clk);
        chk("R8 single stop2", ins_char, ST2);
        ack();
        chk("R8 single done", ins_req, 0);
        sw_flow_en = 1'b0;
        idle(2);
        chk("R7 no req when off", ins_req, 0);
        rx_level = 8'd0;
        tx_sel = 2'b10;
        sw_flow_en = 1'b1;
        idle(3);
        chk("R7 stop memory forgotten", ins_req, 0);
        rx_level = 8'd20;
        @(negedge clk);
        chk("R8 single stop1", ins_char, ST1);
        ack();
        sw_flow_en = 1'b0;
        idle(1);
        sw_flow_en = 1'b1;
        halt_lvl = 4'd0;
        rx_level = 8'd128;
        idle(3);
        chk("R8 halt zero", ins_req, 0);
        sw_flow_en = 1'b0;
        idle(1);
        sw_flow_en = 1'b1;
        halt_lvl = 4'd2;
        tx_sel = 2'b00;
        idle(3);
        chk("R11 selection none", ins_req, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule